// File: doc/BRIEF.md
# Packet Transmit Framer with PN9 Whitening

This block turns bytes from a transmit FIFO into a serial bit stream ready for a modulator. After a start pulse it sends an alternating preamble of a selectable minimum length, then a 16-bit sync word sent once or twice, then the payload bytes, then an optional CRC-16. A PN9 sequence can be XORed onto the payload and CRC bits. The preamble and sync word are never whitened.

The modulator paces the framer with `bit_en`: one bit is produced for every enabled cycle, and `tx_stb` marks it. If the FIFO is still empty when the minimum preamble is finished, the framer keeps sending preamble bytes until data arrives. In fixed-length mode the packet ends when an 8-bit byte counter equals the programmed length. The counter wraps, so a packet longer than 255 bytes can start in unlimited mode and be switched to fixed mode late in the packet, with the length set to the total modulo 256.

Top module: `ptx_framer`

## Requirements
- R1: After reset, and until `start`, the outputs `tx_stb`, `done`, `busy` and `fifo_rd` are all 0.
- R2: The preamble consists of whole bytes 0xAA, sent MSB first (1 first). The minimum byte count is selected by `cfg_pre_sel` values 0..7, giving 2, 3, 4, 6, 8, 12, 16 and 24 bytes.
- R3: The framer checks `fifo_empty` at the end of each preamble byte from the minimum-th byte on. It moves to the sync word only when the FIFO is not empty; otherwise it sends another 0xAA byte.
- R4: The sync word `cfg_sync` is sent MSB first. It is sent once (16 bits), or twice (32 bits) when `cfg_sync_twice` is 1.
- R5: Each cycle with `bit_en` high, while a packet is in progress, produces one bit. That bit appears on `tx_bit` with `tx_stb` high in the next cycle. Payload bytes are sent MSB first. `fifo_rd` pulses in the cycle that consumes a byte's first bit, and the FIFO data is taken as show-ahead.
- R6: When `cfg_white_en` is 1, every payload and CRC bit is XORed with s[0] of a 9-bit state s. The state is loaded with all ones before the first payload bit and updated as s = {s[0]^s[5], s[8:1]} after each payload or CRC bit.
- R7: When `cfg_crc_en` is 1, a CRC-16 is appended after the payload, MSB first. It uses polynomial 0x8005 and initial value 0xFFFF, and is computed MSB first over the unwhitened payload bits.
- R8: With `cfg_fixed_len` 1, the payload ends after the byte at which an 8-bit count of consumed bytes equals `cfg_len`. Length 0 therefore means 256 bytes, and no further FIFO byte is read. `cfg_fixed_len` and `cfg_len` may change during a packet and take effect at the next byte boundary.
- R9: If the FIFO is empty when the next payload byte is needed, no bit is produced (`tx_stb` stays 0) and the framer stays busy until a byte arrives.
- R10: `done` is high for exactly the one cycle that carries the strobe of the packet's last bit (last CRC bit, or last payload bit when CRC is off). `busy` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a packet (taken while idle) |
| bit_en | input | 1 | Bit pacing from the modulator |
| cfg_pre_sel | input | 3 | Minimum preamble length code |
| cfg_sync | input | 16 | Sync word |
| cfg_sync_twice | input | 1 | Send sync word twice |
| cfg_fixed_len | input | 1 | 1 = fixed length, 0 = unlimited |
| cfg_len | input | 8 | Fixed packet length modulo 256 |
| cfg_white_en | input | 1 | Enable PN9 whitening |
| cfg_crc_en | input | 1 | Append CRC-16 |
| fifo_data | input | 8 | Head byte of the TX FIFO |
| fifo_empty | input | 1 | TX FIFO empty flag |
| fifo_rd | output | 1 | Pop the head byte |
| tx_bit | output | 1 | Serial output bit |
| tx_stb | output | 1 | Bit strobe for `tx_bit` |
| done | output | 1 | Last-bit marker |
| busy | output | 1 | Packet in progress |

## Verification
Every `bit_en` cycle yields its bit exactly one clock later through a single output register. The scoreboard therefore samples `tx_stb`/`tx_bit` on the falling edge after each rising edge and assembles the bits into bytes for comparison. A FIFO pop takes effect at the same rising edge as the consumed bit, so the bench model updates its FIFO at the next falling edge and samples `fifo_rd` late in the low phase. `done` is due on the strobe of the final expected byte's last bit, and `busy` is checked two cycles later. Stall and preamble-hold behaviour are checked by watching the strobe count and the received byte stream across windows of 90 to 150 cycles. Both windows are longer than one byte time at the bench's two-in-three bit rate.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SYNC,
        ST_PAY,
        ST_CRC
    } ptx_state_e;

    typedef struct packed {
        logic       raw;
        logic       whiten;
    } ptx_bit_t;

    // minimum preamble bytes per selection code
    function automatic logic [4:0] pre_min_bytes(input logic [2:0] sel);
        logic [4:0] n;
        case (sel)
            3'd0:    n = 5'd2;
            3'd1:    n = 5'd3;
            3'd2:    n = 5'd4;
            3'd3:    n = 5'd6;
            3'd4:    n = 5'd8;
            3'd5:    n = 5'd12;
            3'd6:    n = 5'd16;
            default: n = 5'd24;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ptx_pn9.sv
module ptx_pn9 #(
    parameter int PN_W = 9,
    parameter int TAP  = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic step,
    output logic pn_bit
);
    logic [PN_W-1:0] st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '1;
        end else if (load) begin
            st <= '1;
        end else if (step) begin
            st <= {st[0] ^ st[TAP], st[PN_W-1:1]};
        end
    end

    assign pn_bit = st[0];

    // a maximal-length register never reaches the all-zero lock-up state
    assert_pn_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
        step |=> (st != '0));

endmodule

// File: rtl/ptx_crc.sv
module ptx_crc #(
    parameter int           CRC_W = 16,
    parameter logic [15:0]  POLY  = 16'h8005
) (
    input  logic clk,
    input  logic rst,
    input  logic init,
    input  logic upd,
    input  logic din,
    input  logic shift,
    output logic msb
);
    logic [CRC_W-1:0] crc;
    logic             fb;

    assign fb = crc[CRC_W-1] ^ din;

    always_ff @(posedge clk) begin
        if (rst || init) begin
            crc <= '1;
        end else if (upd) begin
            crc <= {crc[CRC_W-2:0], 1'b0} ^ (fb ? POLY[CRC_W-1:0] : '0);
        end else if (shift) begin
            crc <= {crc[CRC_W-2:0], 1'b0};
        end
    end

    assign msb = crc[CRC_W-1];

    // accumulating and emitting never overlap
    assert_crc_phase_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(upd && shift));

endmodule

// File: rtl/ptx_framer.sv
module ptx_framer
    import ptx_pkg::*;
#(
    parameter int          LEN_W   = 8,
    parameter int          SYNC_W  = 16,
    parameter int          CRC_W   = 16,
    parameter logic [15:0] CRC_POLY = 16'h8005
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              bit_en,
    input  logic [2:0]        cfg_pre_sel,
    input  logic [SYNC_W-1:0] cfg_sync,
    input  logic              cfg_sync_twice,
    input  logic              cfg_fixed_len,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_white_en,
    input  logic              cfg_crc_en,
    input  logic [7:0]        fifo_data,
    input  logic              fifo_empty,
    output logic              fifo_rd,
    output logic              tx_bit,
    output logic              tx_stb,
    output logic              done,
    output logic              busy
);
    localparam int SPAN  = (2 * SYNC_W > CRC_W) ? 2 * SYNC_W : CRC_W;
    localparam int POS_W = $clog2(SPAN);
    localparam int SIX_W = $clog2(SYNC_W);

    ptx_state_e        state;
    logic [POS_W-1:0]  pos;
    logic [4:0]        pre_left;
    logic [7:0]        sh;
    logic              have_byte;
    logic [LEN_W-1:0]  byte_cnt;

    logic              emit, pay_wait, byte_last, pay_end, last_bit;
    logic              sync_last, sync_bit, pn_bit, crc_msb;
    logic              pn_load, pn_step, crc_upd, crc_shift;
    logic [SIX_W-1:0]  sync_idx;
    ptx_bit_t          cur;
    logic              out_bit;

    ptx_pn9 #(.PN_W(9), .TAP(5)) u_pn9 (
        .clk   (clk),
        .rst   (rst),
        .load  (pn_load),
        .step  (pn_step),
        .pn_bit(pn_bit)
    );

    ptx_crc #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .clk  (clk),
        .rst  (rst),
        .init (pn_load),
        .upd  (crc_upd),
        .din  (cur.raw),
        .shift(crc_shift),
        .msb  (crc_msb)
    );

    // ---------------- bit selection ----------------
    assign sync_idx  = pos[SIX_W-1:0];
    assign sync_bit  = cfg_sync[SYNC_W-1-int'(sync_idx)];
    assign sync_last = cfg_sync_twice ? (int'(pos) == 2 * SYNC_W - 1)
                                      : (int'(pos) == SYNC_W - 1);
    assign pay_wait  = (state == ST_PAY) && !have_byte && fifo_empty;
    assign emit      = bit_en && (state != ST_IDLE) && !pay_wait;
    assign byte_last = (pos[2:0] == 3'd7);
    assign pay_end   = cfg_fixed_len && (byte_cnt == cfg_len);

    always_comb begin
        cur.whiten = 1'b0;
        case (state)
            ST_PRE:  cur.raw = ~pos[0];
            ST_SYNC: cur.raw = sync_bit;
            ST_PAY: begin
                cur.raw    = have_byte ? sh[7] : fifo_data[7];
                cur.whiten = cfg_white_en;
            end
            ST_CRC: begin
                cur.raw    = crc_msb;
                cur.whiten = cfg_white_en;
            end
            default: cur.raw = 1'b0;
        endcase
    end

    assign out_bit  = cur.raw ^ (cur.whiten & pn_bit);
    assign last_bit = ((state == ST_CRC) && (int'(pos) == CRC_W - 1)) ||
                      ((state == ST_PAY) && have_byte && byte_last && pay_end && !cfg_crc_en);

    assign pn_load   = (state == ST_IDLE) && start;
    assign pn_step   = emit && ((state == ST_PAY) || (state == ST_CRC));
    assign crc_upd   = emit && (state == ST_PAY);
    assign crc_shift = emit && (state == ST_CRC);
    assign fifo_rd   = emit && (state == ST_PAY) && !have_byte;
    assign busy      = (state != ST_IDLE);

    // ---------------- sequencing ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            pos       <= '0;
            pre_left  <= '0;
            sh        <= '0;
            have_byte <= 1'b0;
            byte_cnt  <= '0;
            tx_bit    <= 1'b0;
            tx_stb    <= 1'b0;
            done      <= 1'b0;
        end else begin
            tx_stb <= emit;
            done   <= emit && last_bit;
            if (emit) tx_bit <= out_bit;

            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state     <= ST_PRE;
                        pos       <= '0;
                        pre_left  <= pre_min_bytes(cfg_pre_sel);
                        byte_cnt  <= '0;
                        have_byte <= 1'b0;
                    end
                end
                ST_PRE: begin
                    if (emit) begin
                        if (byte_last) begin
                            pos <= '0;
                            if (pre_left > 5'd1) pre_left <= pre_left - 5'd1;
                            else if (!fifo_empty) state <= ST_SYNC;
                        end else begin
                            pos <= pos + 1'b1;
                        end
                    end
                end
                ST_SYNC: begin
                    if (emit) begin
                        if (sync_last) begin
                            pos   <= '0;
                            state <= ST_PAY;
                        end else begin
                            pos <= pos + 1'b1;
                        end
                    end
                end
                ST_PAY: begin
                    if (emit) begin
                        if (!have_byte) begin
                            sh        <= {fifo_data[6:0], 1'b0};
                            have_byte <= 1'b1;
                            byte_cnt  <= byte_cnt + 1'b1;
                            pos       <= POS_W'(1);
                        end else if (byte_last) begin
                            have_byte <= 1'b0;
                            pos       <= '0;
                            if (pay_end) state <= cfg_crc_en ? ST_CRC : ST_IDLE;
                        end else begin
                            sh  <= {sh[6:0], 1'b0};
                            pos <= pos + 1'b1;
                        end
                    end
                end
                ST_CRC: begin
                    if (emit) begin
                        if (int'(pos) == CRC_W - 1) begin
                            pos   <= '0;
                            state <= ST_IDLE;
                        end else begin
                            pos <= pos + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // ---------------- assertions ----------------
    logic in_sync;
    assign in_sync = (state == ST_SYNC);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> (!tx_stb && !done));

    assert_min_preamble_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(in_sync) |-> ($past(pre_left) == 5'd1));

    assert_sync_needs_data_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(in_sync) |-> $past(!fifo_empty));

    assert_pop_in_payload_R5: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> (state == ST_PAY));

    assert_done_with_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> (tx_stb && !busy));

endmodule

// File: tb/ptx_framer_bench.sv
`timescale 1ns/1ps
module ptx_framer_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        start, bit_en;
    logic [2:0]  cfg_pre_sel;
    logic [15:0] cfg_sync;
    logic        cfg_sync_twice, cfg_fixed_len, cfg_white_en, cfg_crc_en;
    logic [7:0]  cfg_len;
    logic [7:0]  fifo_data;
    logic        fifo_empty;
    logic        fifo_rd, tx_bit, tx_stb, done, busy;

    always #4 clk = ~clk;

    ptx_framer u_ptx_framer (
        .clk(clk), .rst(rst), .start(start), .bit_en(bit_en),
        .cfg_pre_sel(cfg_pre_sel), .cfg_sync(cfg_sync), .cfg_sync_twice(cfg_sync_twice),
        .cfg_fixed_len(cfg_fixed_len), .cfg_len(cfg_len), .cfg_white_en(cfg_white_en),
        .cfg_crc_en(cfg_crc_en), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
        .fifo_rd(fifo_rd), .tx_bit(tx_bit), .tx_stb(tx_stb), .done(done), .busy(busy)
    );

    int checks = 0, failures = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- FIFO model ----------------
    logic [7:0] fq[$];
    logic [7:0] pay[$];
    int  popped = 0;
    bit  pend_pop = 0;
    int  ph = 0;

    always @(negedge clk) begin
        if (pend_pop && fq.size() > 0) begin
            void'(fq.pop_front());
            popped++;
        end
        ph     = (ph + 1) % 3;
        bit_en <= (ph != 2);
        #1;
        fifo_empty = (fq.size() == 0);
        fifo_data  = (fq.size() > 0) ? fq[0] : 8'h00;
        #2;
        pend_pop = fifo_rd;
    end

    // ---------------- scoreboard ----------------
    logic [7:0] exp_q[$];
    int    pre_min, pre_got, extra_got, nbits, strobes;
    bit    allow_extra, in_pre, pkt_over;
    logic [7:0] acc;
    string cur_tag;

    always @(negedge clk) begin
        logic [7:0] e;
        if (tx_stb) begin
            strobes++;
            acc = {acc[6:0], tx_bit};
            nbits++;
            if (nbits == 8) begin
                nbits = 0;
                if (in_pre && pre_got < pre_min) begin
                    chk(acc == 8'hAA, "R2 preamble byte", acc, 8'hAA);
                    pre_got++;
                end else if (in_pre && allow_extra && acc == 8'hAA) begin
                    extra_got++;
                end else begin
                    in_pre = 0;
                    if (exp_q.size() == 0) begin
                        chk(0, "R8 byte after packet end", acc, 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(acc == e, cur_tag, acc, e);
                        if (exp_q.size() == 0) begin
                            chk(done == 1'b1, "R10 done on last bit", done, 1);
                            pkt_over = 1;
                        end
                    end
                end
            end
            if (done && !(nbits == 0 && pkt_over))
                chk(0, "R10 early done", done, 0);
        end else if (done) begin
            chk(0, "R10 done without strobe", done, 0);
        end
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- expected model ----------------
    function automatic int min_pre(input logic [2:0] s);
        int t[8] = '{2, 3, 4, 6, 8, 12, 16, 24};
        return t[s];
    endfunction

    task automatic build_expected();
        logic [8:0]  pn  = 9'h1FF;
        logic [15:0] crc = 16'hFFFF;
        logic [7:0]  ob;
        logic        b, w;
        exp_q.delete();
        exp_q.push_back(cfg_sync[15:8]);
        exp_q.push_back(cfg_sync[7:0]);
        if (cfg_sync_twice) begin
            exp_q.push_back(cfg_sync[15:8]);
            exp_q.push_back(cfg_sync[7:0]);
        end
        foreach (pay[i]) begin
            for (int k = 7; k >= 0; k--) begin
                b   = pay[i][k];
                crc = {crc[14:0], 1'b0} ^ ((crc[15] ^ b) ? 16'h8005 : 16'h0);
                w   = b ^ (cfg_white_en & pn[0]);
                pn  = {pn[0] ^ pn[5], pn[8:1]};
                ob  = {ob[6:0], w};
            end
            exp_q.push_back(ob);
        end
        if (cfg_crc_en) begin
            for (int k = 15; k >= 0; k--) begin
                w  = crc[k] ^ (cfg_white_en & pn[0]);
                pn = {pn[0] ^ pn[5], pn[8:1]};
                ob = {ob[6:0], w};
                if (k % 8 == 0) exp_q.push_back(ob);
            end
        end
    endtask

    task automatic arm(input logic [2:0] sel, input bit extra, input string tag);
        cfg_pre_sel = sel;
        pre_min = min_pre(sel);
        pre_got = 0; extra_got = 0; nbits = 0;
        allow_extra = extra; in_pre = 1; pkt_over = 0;
        cur_tag = tag; popped = 0;
        build_expected();
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic finish_pkt();
        while (!pkt_over) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R10 idle after done", busy, 0);
    endtask

    task automatic feed_run(input int total, input int sw_at, input logic [7:0] new_len);
        int  pushed = 0;
        bit  sw = 0;
        while (!pkt_over) begin
            @(negedge clk);
            if (pushed < total && fq.size() < 64) begin
                fq.push_back(pay[pushed]);
                pushed++;
            end
            if (sw_at >= 0 && !sw && popped >= sw_at) begin
                cfg_fixed_len = 1'b1;
                cfg_len = new_len;
                sw = 1;
            end
        end
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int snap;
        rst = 1'b1; start = 1'b0; bit_en = 1'b0;
        cfg_pre_sel = 0; cfg_sync = 16'hD391; cfg_sync_twice = 0;
        cfg_fixed_len = 1; cfg_len = 8'd4; cfg_white_en = 0; cfg_crc_en = 0;
        fifo_data = 0; fifo_empty = 1;
        acc = 0; strobes = 0; pkt_over = 0; in_pre = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_stb == 0, "R1 tx_stb after reset", tx_stb, 0);
        chk(done == 0,   "R1 done after reset", done, 0);
        chk(busy == 0,   "R1 busy after reset", busy, 0);
        chk(fifo_rd == 0, "R1 fifo_rd after reset", fifo_rd, 0);

        // minimum preamble, single sync, plain 4-byte fixed payload; one spare byte
        pay = '{8'h01, 8'h80, 8'hFF, 8'h5A};
        cfg_sync = 16'hD391; cfg_sync_twice = 0; cfg_fixed_len = 1; cfg_len = 8'd4;
        cfg_white_en = 0; cfg_crc_en = 0;
        arm(3'd0, 0, "R4 R5 plain stream");
        fq = '{8'h01, 8'h80, 8'hFF, 8'h5A, 8'hC3};
        pulse_start();
        finish_pkt();
        chk(fq.size() == 1, "R8 spare byte not read", fq.size(), 1);

        // 12-byte preamble, doubled sync, whitening + CRC
        pay.delete();
        for (int i = 0; i < 10; i++) pay.push_back(8'(i * 37 + 3));
        cfg_sync = 16'h7E19; cfg_sync_twice = 1; cfg_len = 8'd10;
        cfg_white_en = 1; cfg_crc_en = 1;
        arm(3'd5, 0, "R4 R6 R7 whitened stream");
        fq.delete();
        foreach (pay[i]) fq.push_back(pay[i]);
        pulse_start();
        finish_pkt();

        // preamble held while the FIFO is empty
        pay = '{8'h3C, 8'hA5, 8'h00};
        cfg_sync = 16'hD391; cfg_sync_twice = 0; cfg_len = 8'd3;
        cfg_white_en = 0; cfg_crc_en = 1;
        arm(3'd1, 1, "R3 R7 stream after hold");
        fq.delete();
        pulse_start();
        repeat (150) @(negedge clk);
        chk(busy == 1 && in_pre, "R3 still in preamble", {busy, in_pre}, 2'b11);
        chk(pre_got == pre_min, "R2 minimum preamble count", pre_got, pre_min);
        foreach (pay[i]) fq.push_back(pay[i]);
        finish_pkt();
        chk(extra_got > 0, "R3 extra preamble bytes", extra_got, 1);

        // payload stall in unlimited mode, then late switch to fixed length 5
        pay = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
        cfg_fixed_len = 0; cfg_len = 8'd0; cfg_white_en = 1; cfg_crc_en = 1;
        arm(3'd2, 0, "R5 R6 R7 stalled stream");
        fq = '{8'h11, 8'h22, 8'h33};
        pulse_start();
        while (!(popped == 3 && fq.size() == 0)) @(negedge clk);
        repeat (60) @(negedge clk);
        snap = strobes;
        repeat (90) @(negedge clk);
        chk(strobes == snap, "R9 no strobe while starved", strobes, snap);
        chk(busy == 1, "R9 busy while starved", busy, 1);
        cfg_fixed_len = 1; cfg_len = 8'd5;
        fq.push_back(8'h44); fq.push_back(8'h55);
        finish_pkt();

        // length 0 means 256 bytes; a 257th byte stays in the FIFO
        pay.delete();
        for (int i = 0; i < 257; i++) pay.push_back(8'(i ^ 8'h5C));
        cfg_fixed_len = 1; cfg_len = 8'd0; cfg_white_en = 0; cfg_crc_en = 0;
        pay.delete();
        for (int i = 0; i < 256; i++) pay.push_back(8'(i ^ 8'h5C));
        arm(3'd7, 0, "R8 256-byte packet");
        pay.push_back(8'hEE);
        fq.delete();
        pulse_start();
        feed_run(257, -1, 8'd0);
        repeat (2) @(negedge clk);
        chk(fq.size() == 1, "R8 length 0 stops at 256", fq.size(), 1);
        chk(busy == 0, "R10 idle after 256-byte packet", busy, 0);

        // 600-byte packet: unlimited start, fixed length 88 after 345 bytes
        pay.delete();
        for (int i = 0; i < 600; i++) pay.push_back(8'((i * 7) ^ (i >> 3)));
        cfg_fixed_len = 0; cfg_len = 8'd0; cfg_white_en = 1; cfg_crc_en = 1;
        cfg_sync_twice = 1;
        arm(3'd3, 0, "R8 R6 R7 600-byte packet");
        fq.delete();
        pulse_start();
        feed_run(600, 345, 8'd88);
        repeat (2) @(negedge clk);
        chk(popped == 600, "R8 modulo length end", popped, 600);
        chk(busy == 0, "R10 idle after long packet", busy, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule